// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes the SDRAM command bus from the end of reset until the memory is ready for normal traffic. It first fills a long stabilization interval with NOP commands. It then precharges every bank and issues two auto refresh commands. Finally it loads the mode register with a word built from its field inputs. The NOP gap after each command is a parameter counted in clocks. When the last gap has elapsed, the block raises `init_done` and holds the bus at NOP, so that a downstream controller can take over.

The stabilization interval is `CLK_MHZ * STABLE_US` clocks, which is 12500 with the defaults. The command pins are decoded from the sequencer state, so they change just after the rising edge that moves the state. The SDRAM registers each command on the following rising edge.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: During reset, and for the first `CLK_MHZ*STABLE_US - 1` cycles after reset is released (sampled after rising edges 1 to STAB-1), the bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111) with all address and bank bits 0. `init_done` is 0 during this time.
- R2: After rising edge STAB following reset release, exactly one precharge command (0010) appears. Its addr[10] is 1 and all other address and bank bits are 0.
- R3: The precharge is followed by exactly `T_RP` NOP cycles, and then one auto refresh command (0001) with address and bank 0.
- R4: The first refresh is followed by exactly `T_RFC` NOP cycles, a second refresh, and another `T_RFC` NOP cycles. No further refresh follows.
- R5: A single load-mode command (0000) comes next. Its address word is addr[2:0]=burst length, addr[3]=burst type, addr[6:4]=CAS latency, addr[8:7]=00 and addr[9]=write burst mode, with every higher address bit 0 and bank 00.
- R6: After the load-mode command come exactly `T_MRD` NOP cycles. `init_done` goes to 1 in the cycle after the last of them.
- R7: Once high, `init_done` stays high and the bus stays at NOP with address 0 until reset.
- R8: A reset asserted partway through the sequence returns the bus to NOP and `init_done` to 0. After release, the full sequence restarts from the stabilization interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_len_i | input | 3 | Burst length code for the mode word |
| burst_type_i | input | 1 | Burst type bit for the mode word |
| cas_lat_i | input | 3 | CAS latency code for the mode word |
| write_burst_i | input | 1 | Write burst mode bit for the mode word |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | 2 | Bank address pins |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench predicts the bus on every cycle of the sequence, so an off-by-one in any gap shows up at once. A gap one cycle short or long would move a refresh, the load-mode command or `init_done` by a cycle, and a timer that reloaded wrongly would stretch the stabilization interval. The mode word is checked with two field sets of opposite bit patterns, which exposes a field landing on the wrong address bits. A reset during the first refresh gap checks that a sequencer which kept a partial count, or skipped the stabilization wait after restart, produces a precharge too early.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // command code packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_MRS = 4'b0000
  } cmd_e;

  typedef enum logic [3:0] {
    ST_STAB,
    ST_PRE,
    ST_TRP,
    ST_REF1,
    ST_TRFC1,
    ST_REF2,
    ST_TRFC2,
    ST_MRS,
    ST_TMRD,
    ST_DONE
  } seq_state_e;

  function automatic int unsigned stab_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // mode word: [2:0] burst length, [3] burst type, [6:4] CAS latency,
  // [8:7] operating mode (standard = 00), [9] write burst mode
  function automatic logic [9:0] pack_mode(input logic [2:0] bl, input logic bt,
                                           input logic [2:0] cl, input logic wb);
    return {wb, 2'b00, cl, bt, bl};
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= CNT_W'(RST_VAL);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3: an expired timer never wraps around on its own
  a_r3_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RFC = 9,
  parameter int unsigned T_MRD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output cmd_e             cmd,
  output logic             init_done
);

  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  seq_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_STAB:  if (tmr_zero) state_nx = ST_PRE;
      ST_PRE:   begin state_nx = ST_TRP;   tmr_load = 1'b1; tmr_val = LD_RP;  end
      ST_TRP:   if (tmr_zero) state_nx = ST_REF1;
      ST_REF1:  begin state_nx = ST_TRFC1; tmr_load = 1'b1; tmr_val = LD_RFC; end
      ST_TRFC1: if (tmr_zero) state_nx = ST_REF2;
      ST_REF2:  begin state_nx = ST_TRFC2; tmr_load = 1'b1; tmr_val = LD_RFC; end
      ST_TRFC2: if (tmr_zero) state_nx = ST_MRS;
      ST_MRS:   begin state_nx = ST_TMRD;  tmr_load = 1'b1; tmr_val = LD_MRD; end
      ST_TMRD:  if (tmr_zero) state_nx = ST_DONE;
      default:  state_nx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_STAB;
    else        state <= state_nx;
  end

  always_comb begin
    unique case (state)
      ST_PRE:           cmd = CMD_PRE;
      ST_REF1, ST_REF2: cmd = CMD_REF;
      ST_MRS:           cmd = CMD_MRS;
      default:          cmd = CMD_NOP;
    endcase
  end

  assign init_done = (state == ST_DONE);

  logic is_ref;
  assign is_ref = (cmd == CMD_REF);

  // R4: a refresh is always followed by NOP gap cycles
  a_r4_ref_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> (cmd == CMD_NOP));

  // R7: done is sticky until reset
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7: after done only NOP is driven
  a_r7_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == CMD_NOP));

  // R6: done rises only after a NOP cycle of the mode wait
  a_r6_done_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> ($past(cmd) == CMD_NOP));

endmodule

// File: rtl/sdram_init_addr.sv
module sdram_init_addr
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  cmd_e              cmd,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              write_burst_i,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba
);

  logic [9:0] mode_word;
  assign mode_word = pack_mode(burst_len_i, burst_type_i, cas_lat_i, write_burst_i);

  always_comb begin
    addr = '0;
    ba   = 2'b00;
    unique case (cmd)
      CMD_PRE: addr[10]  = 1'b1;
      CMD_MRS: addr[9:0] = mode_word;
      default: addr      = '0;
    endcase
  end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 125,
  parameter int unsigned STABLE_US = 100,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 9,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned ADDR_W    = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              write_burst_i,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              init_done
);

  localparam int unsigned STAB  = stab_cycles(CLK_MHZ, STABLE_US);
  localparam int unsigned MAXC  = max_of4(STAB, T_RP, T_RFC, T_MRD);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  cmd_e             cmd;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(STAB - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_init_fsm #(.CNT_W(CNT_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .cmd(cmd), .init_done(init_done)
  );

  sdram_init_addr #(.ADDR_W(ADDR_W)) u_addr (
    .cmd(cmd), .burst_len_i(burst_len_i), .burst_type_i(burst_type_i),
    .cas_lat_i(cas_lat_i), .write_burst_i(write_burst_i), .addr(addr), .ba(ba)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;

  logic is_pre, is_mrs;
  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_mrs = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);

  // R2: precharge targets all banks
  a_r2_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (addr[10] && ba == 2'b00));

  // R5: mode load keeps reserved bits and bank clear
  a_r5_mrs_clean: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (ba == 2'b00 && addr[8:7] == 2'b00 && addr[ADDR_W-1:10] == '0));

  // R1: nothing but NOP while init_done is low and the timer is still in the wait
  a_r1_wait_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_zero && !init_done && !tmr_load) |-> cs_n == 1'b0 && ras_n && cas_n && we_n);

endmodule

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;

  localparam int CLK_MHZ = 125, STABLE_US = 100;
  localparam int T_RP = 3, T_RFC = 9, T_MRD = 2, ADDR_W = 13;
  localparam int STAB = CLK_MHZ * STABLE_US;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bl = 3'd0, cl = 3'd0;
  logic bt = 1'b0, wb = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, init_done;
  logic [ADDR_W-1:0] addr;
  logic [1:0] ba;

  always #10 clk = ~clk;

  sdram_pwrup_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP),
                    .T_RFC(T_RFC), .T_MRD(T_MRD), .ADDR_W(ADDR_W)) i_sdram_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .burst_len_i(bl), .burst_type_i(bt), .cas_lat_i(cl),
    .write_burst_i(wb), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );

  typedef struct packed {
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        ba;
    logic              done;
  } obs_t;

  typedef struct {
    obs_t  v;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;
  obs_t got;
  item_t cur;

  function automatic obs_t sample();
    obs_t s;
    s.cmd = {cs_n, ras_n, cas_n, we_n};
    s.addr = addr;
    s.ba = ba;
    s.done = init_done;
    return s;
  endfunction

  task automatic report(input string tag, input obs_t act, input obs_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got cmd=%b addr=%h ba=%b done=%b, expected cmd=%b addr=%h ba=%b done=%b",
               tag, act.cmd, act.addr, act.ba, act.done, exp.cmd, exp.addr, exp.ba, exp.done);
    end
  endtask

  // monitor: compares one predicted item per cycle once reset is released
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      cur = q.pop_front();
      got = sample();
      report(cur.tag, got, cur.v);
    end
  end

  task automatic push(input logic [3:0] c, input int a, input logic d, input string tag);
    item_t it;
    it.v.cmd = c;
    it.v.addr = ADDR_W'(a);
    it.v.ba = 2'b00;
    it.v.done = d;
    it.tag = tag;
    q.push_back(it);
  endtask

  // predicts the bus sample by sample after reset release, up to limit items
  task automatic predict(input int limit);
    int n = 0;
    int mw = int'(bl) + int'(bt) * 8 + int'(cl) * 16 + int'(wb) * 512;
    for (int i = 1; i < STAB; i++) begin if (n < limit) push(4'b0111, 0, 1'b0, "R1"); n++; end
    if (n < limit) push(4'b0010, 1024, 1'b0, "R2"); n++;
    for (int i = 0; i < T_RP; i++) begin if (n < limit) push(4'b0111, 0, 1'b0, "R3"); n++; end
    if (n < limit) push(4'b0001, 0, 1'b0, "R3"); n++;
    for (int i = 0; i < T_RFC; i++) begin if (n < limit) push(4'b0111, 0, 1'b0, "R4"); n++; end
    if (n < limit) push(4'b0001, 0, 1'b0, "R4"); n++;
    for (int i = 0; i < T_RFC; i++) begin if (n < limit) push(4'b0111, 0, 1'b0, "R4"); n++; end
    if (n < limit) push(4'b0000, mw, 1'b0, "R5"); n++;
    for (int i = 0; i < T_MRD; i++) begin if (n < limit) push(4'b0111, 0, 1'b0, "R6"); n++; end
    if (n < limit) push(4'b0111, 0, 1'b1, "R6"); n++;
    for (int i = 0; i < 30; i++) begin if (n < limit) push(4'b0111, 0, 1'b1, "R7"); n++; end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    obs_t e;
    e.cmd = 4'b0111; e.addr = '0; e.ba = 2'b00; e.done = 1'b0;
    @(negedge clk);
    report(tag, sample(), e);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n <= 1'b1;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n <= 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_up();
  end

  initial begin
    // first run: one field pattern
    bl = 3'b011; bt = 1'b1; cl = 3'b010; wb = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    predict(1 << 30);
    release_reset();
    drain();

    // reset in the middle of the first refresh gap (R8)
    enter_reset();
    check_reset_state("R8");
    predict(STAB + T_RP + 5);
    release_reset();
    drain();
    enter_reset();
    check_reset_state("R8");

    // full rerun with the opposite field pattern after a mid-sequence reset (R8, R5)
    bl = 3'b100; bt = 1'b0; cl = 3'b101; wb = 1'b1;
    predict(1 << 30);
    release_reset();
    drain();
    finish_up();
  end

endmodule